// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM array out of power-up before ordinary traffic is allowed. From reset it counts a settling delay of a configured length in microseconds, converted to clock cycles from a clock-frequency parameter. Software arms the block with a request bit. The first write aimed at the SDRAM space while the block is armed acts as a dummy trigger. Its data is thrown away, and the bus master is held until the whole sequence has run.

Once triggered and settled, the block drives a fixed command train on the shared command pins. It issues one precharge-all, then a parameterized number of auto-refreshes (eight by default), then a mode-register load. Every device sits on the same address bus, so all of them take the mode word in the same cycle. The mode word always selects single-beat access and carries a CAS latency taken from a configuration input. When the train ends, the block acknowledges the dummy write and raises a sticky ready flag.

Top module: `sdram_boot_seq`

## Requirements
- R1: No command other than NOP appears until at least PWR_US×CLK_MHZ cycles after reset release. When the trigger arrives before the delay has elapsed, the precharge-all appears on the first cycle after the delay (cycle PWR_US×CLK_MHZ+1).
- R2: The first command is a single precharge-all (cs_n,ras_n,cas_n,we_n = 0,0,1,0) with address bit 10 set, all other address bits zero and bank 0. It is followed by exactly N_REF auto-refreshes (0,0,0,1) with address and bank zero. The first refresh comes T_RP cycles after the precharge, and each further refresh comes T_RFC cycles after the one before it.
- R3: T_RFC cycles after the last refresh, a mode-register load (0,0,0,0) appears with bank 0 and the mode word on the address pins.
- R4: The mode word has burst length bits [2:0]=000, burst type bit 3=0 (sequential), CAS latency in bits [6:4] equal to cas_lat, bits [8:7]=00, write-burst bit 9=1 (single access), and every higher bit 0.
- R5: On every cycle that does not carry one of the commands above, including the whole settling delay, the pins hold NOP (0,1,1,1).
- R6: A write (wr_valid=1) while init_req=0 and init_active=0 is ignored. No command is issued, wr_ack stays 0 and init_active stays 0.
- R7: wr_ack is a single-cycle pulse T_MRD cycles after the mode-register load. init_active rises in that same cycle and stays 1 until reset.
- R8: Once init_active is 1, writes with init_req=1 start no new sequence. No command is issued and no wr_ack is produced.
- R9: When the trigger write is first presented after the delay has elapsed, the precharge-all appears on the second rising edge after that.
- R10: During reset the pins hold NOP and wr_ack and init_active are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release marks power-up |
| init_req | input | 1 | Software arm bit for initialization |
| wr_valid | input | 1 | Write to SDRAM space, held until acknowledged |
| cas_lat | input | CL_W | CAS latency placed in the mode word |
| wr_ack | output | 1 | One-cycle acknowledge of the dummy write |
| init_active | output | 1 | Sticky flag: initialization finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus, also carries the mode word |
| sd_ba | output | BA_W | Bank select |

## Verification
The hardest case to reach is a trigger that lands after the settling delay has already run out. A broken design would then start at once on an unarmed write, or would add extra delay to an armed one. To get there, the second run waits several hundred cycles past the delay and first presents writes with the arm bit clear, where any stray command would show up immediately. Only then does it arm and present the trigger, and it checks the exact cycle of the precharge. The first run covers the opposite case, an early trigger, so both ways of ending the delay are exercised, each with its own CAS latency.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PWAIT   = 3'd1,
        ST_GAP_PRE = 3'd2,
        ST_GAP_REF = 3'd3,
        ST_GAP_MRS = 3'd4,
        ST_DONE    = 3'd5
    } seq_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int WAIT_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIMIT);

    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R1

endmodule

// File: rtl/sdram_boot_mode.sv
module sdram_boot_mode #(
    parameter int ADDR_W = 13,
    parameter int CL_W   = 3
) (
    input  logic [CL_W-1:0]   cas_lat,
    output logic [ADDR_W-1:0] mode_word
);
    localparam int CL_LSB  = 4;
    localparam int WB_BIT  = 9;

    always_comb begin
        mode_word = '0;
        for (int i = 0; i < CL_W; i++) begin
            mode_word[CL_LSB + i] = cas_lat[i];
        end
        mode_word[WB_BIT] = 1'b1;
    end

endmodule

// File: rtl/sdram_boot_pins.sv
module sdram_boot_pins
    import sdram_boot_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sd_cmd_e           cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BA_W-1:0]   ba_o
);
    typedef struct packed {
        sd_pins_t          pins;
        logic [ADDR_W-1:0] addr;
    } pin_reg_t;

    localparam sd_pins_t P_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    pin_reg_t pr_d, pr_q;

    always_comb begin
        pr_d.addr = addr_i;
        unique case (cmd_i)
            CMD_PRE: pr_d.pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: pr_d.pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MRS: pr_d.pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: begin
                pr_d.pins = P_NOP;
                pr_d.addr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q.pins <= P_NOP;
            pr_q.addr <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign cs_n   = pr_q.pins.cs_n;
    assign ras_n  = pr_q.pins.ras_n;
    assign cas_n  = pr_q.pins.cas_n;
    assign we_n   = pr_q.pins.we_n;
    assign addr_o = pr_q.addr;
    assign ba_o   = '0;

    AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n) |-> (addr_o[10] && $countones(addr_o) == 1)); // R2

    AST_REF_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> (addr_o == '0)); // R2

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_MHZ = 250,
    parameter int PWR_US  = 100,
    parameter int T_RP    = 5,
    parameter int T_RFC   = 18,
    parameter int T_MRD   = 2,
    parameter int N_REF   = 8,
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int CL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              wr_valid,
    input  logic [CL_W-1:0]   cas_lat,
    output logic              wr_ack,
    output logic              init_active,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);
    localparam int WAIT_CYC = CLK_MHZ * PWR_US;
    localparam int GAP_MAX  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                             : ((T_RP  > T_MRD) ? T_RP  : T_MRD);
    localparam int GAP_W    = $clog2(GAP_MAX + 1);
    localparam int REF_W    = $clog2(N_REF + 1);

    localparam logic [GAP_W-1:0] GAP_RP  = GAP_W'(T_RP - 1);
    localparam logic [GAP_W-1:0] GAP_RFC = GAP_W'(T_RFC - 1);
    localparam logic [GAP_W-1:0] GAP_MRD = GAP_W'(T_MRD - 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [GAP_W-1:0] gap;
        logic [REF_W-1:0] nref;
        logic             ack;
        logic             active;
    } seq_t;

    seq_t              s_d, s_q;
    sd_cmd_e           cmd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [ADDR_W-1:0] mode_word;
    logic              pwr_done;

    sdram_boot_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sdram_boot_mode #(.ADDR_W(ADDR_W), .CL_W(CL_W)) u_mode (
        .cas_lat   (cas_lat),
        .mode_word (mode_word)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        cmd      = CMD_NOP;
        cmd_addr = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (wr_valid && init_req && !s_q.active) s_d.st = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (pwr_done) begin
                    cmd          = CMD_PRE;
                    cmd_addr[10] = 1'b1;
                    s_d.gap      = GAP_RP;
                    s_d.st       = ST_GAP_PRE;
                end
            end
            ST_GAP_PRE: begin
                if (s_q.gap == '0) begin
                    cmd      = CMD_REF;
                    s_d.gap  = GAP_RFC;
                    s_d.nref = '0;
                    s_d.st   = ST_GAP_REF;
                end else begin
                    s_d.gap = s_q.gap - 1'b1;
                end
            end
            ST_GAP_REF: begin
                if (s_q.gap == '0) begin
                    if (s_q.nref == REF_LAST) begin
                        cmd      = CMD_MRS;
                        cmd_addr = mode_word;
                        s_d.gap  = GAP_MRD;
                        s_d.st   = ST_GAP_MRS;
                    end else begin
                        cmd      = CMD_REF;
                        s_d.gap  = GAP_RFC;
                        s_d.nref = s_q.nref + 1'b1;
                    end
                end else begin
                    s_d.gap = s_q.gap - 1'b1;
                end
            end
            ST_GAP_MRS: begin
                if (s_q.gap == '0) begin
                    s_d.st     = ST_DONE;
                    s_d.ack    = 1'b1;
                    s_d.active = 1'b1;
                end else begin
                    s_d.gap = s_q.gap - 1'b1;
                end
            end
            default: begin
                s_d.st = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.gap    <= '0;
            s_q.nref   <= '0;
            s_q.ack    <= 1'b0;
            s_q.active <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_boot_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .addr_i (cmd_addr),
        .cs_n   (sd_cs_n),
        .ras_n  (sd_ras_n),
        .cas_n  (sd_cas_n),
        .we_n   (sd_we_n),
        .addr_o (sd_addr),
        .ba_o   (sd_ba)
    );

    assign wr_ack      = s_q.ack;
    assign init_active = s_q.active;

    AST_CMD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> pwr_done); // R1

    AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.nref <= REF_LAST)); // R2

    AST_MRS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
            |-> (sd_addr[2:0] == 3'b000 && !sd_addr[3] && sd_addr[9] && sd_ba == '0)); // R4

    AST_UNARMED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !init_req) |=> !wr_ack); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack); // R7

    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_active |=> init_active); // R7

    AST_ACTIVE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_active) |-> wr_ack); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE) |-> (cmd == CMD_NOP && !s_d.ack)); // R8

endmodule

// File: tb/sim_sdram_boot_seq.sv
`timescale 1ns/1ps
module sim_sdram_boot_seq;
    localparam int CLK_MHZ = 250;
    localparam int PWR_US  = 100;
    localparam int T_RP    = 5;
    localparam int T_RFC   = 18;
    localparam int T_MRD   = 2;
    localparam int N_REF   = 8;
    localparam int WAIT_CYC = CLK_MHZ * PWR_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  cas_lat = 3'd0;
    logic        wr_ack, init_active;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;

    sdram_boot_seq #(
        .CLK_MHZ(CLK_MHZ), .PWR_US(PWR_US), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .N_REF(N_REF), .ADDR_W(13), .BA_W(2), .CL_W(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .wr_valid(wr_valid),
        .cas_lat(cas_lat), .wr_ack(wr_ack), .init_active(init_active),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    typedef struct {
        logic [3:0]  pins;
        logic [12:0] addr;
        int          gap;
        string       tag;
    } item_t;

    item_t expq[$];
    int errors = 0, checks = 0;
    int last_cmd = 0, pre_exact = 0, acks = 0, ncmd = 0;
    string pre_tag = "R1";

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected commands and checks the acknowledge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] pins;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!(pins inside {4'b0111, 4'b0010, 4'b0001, 4'b0000}))
                chk(0, "R5", "illegal pin code", pins, 7);
            if (pins != 4'b0111) begin
                ncmd++;
                if (expq.size() == 0) begin
                    chk(0, "R8", "command with none expected", pins, 7);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    chk(pins == it.pins, it.tag, "command code", pins, it.pins);
                    chk(sd_addr == it.addr, it.tag, "address", sd_addr, it.addr);
                    chk(sd_ba == 2'd0, it.tag, "bank", sd_ba, 0);
                    if (it.gap > 0)
                        chk(cyc - last_cmd == it.gap, it.tag, "spacing", cyc - last_cmd, it.gap);
                    else
                        chk(cyc == pre_exact && cyc >= WAIT_CYC, pre_tag, "precharge cycle", cyc, pre_exact);
                    last_cmd = cyc;
                end
            end
            if (wr_ack) begin
                acks++;
                chk(expq.size() == 0, "R7", "ack before sequence end", expq.size(), 0);
                chk(cyc - last_cmd == T_MRD, "R7", "ack delay after mode load", cyc - last_cmd, T_MRD);
                chk(init_active == 1'b1, "R7", "active with ack", init_active, 1);
            end else if (init_active && acks == 0) begin
                chk(0, "R7", "active before ack", 1, 0);
            end
        end
    end

    // driver: pushes the expected train, then raises the trigger write
    task automatic do_init(input logic [2:0] cl, input bit late);
        item_t it;
        int ack_wait;
        cas_lat = cl;
        it.pins = 4'b0010; it.addr = 13'h400; it.gap = 0; it.tag = "R2";
        expq.push_back(it);
        for (int i = 0; i < N_REF; i++) begin
            it.pins = 4'b0001; it.addr = 13'h0;
            it.gap = (i == 0) ? T_RP : T_RFC; it.tag = "R2";
            expq.push_back(it);
        end
        it.pins = 4'b0000; it.addr = 13'h200 | (13'(cl) << 4); it.gap = T_RFC; it.tag = "R4";
        expq.push_back(it);
        @(negedge clk);
        pre_exact = late ? cyc + 2 : WAIT_CYC + 1;
        pre_tag   = late ? "R9" : "R1";
        init_req  = 1'b1;
        wr_valid  = 1'b1;
        ack_wait  = 0;
        while (!wr_ack && ack_wait < 40000) begin
            @(negedge clk);
            ack_wait++;
        end
        wr_valid = 1'b0;
        chk(wr_ack == 1'b1, "R7", "dummy write acknowledged", wr_ack, 1);
        chk(expq.size() == 0, "R3", "train complete", expq.size(), 0);
        chk(ncmd == N_REF + 2, "R5", "command count", ncmd, N_REF + 2);
    endtask

    task automatic reset_phase();
        rst_n = 1'b0; init_req = 1'b0; wr_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10", "reset pins",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
            chk(!wr_ack && !init_active, "R10", "reset flags", {wr_ack, init_active}, 0);
        end
        rst_n = 1'b1;
        acks = 0; ncmd = 0;
    endtask

    initial begin
        reset_phase();
        // unarmed writes during the settling delay
        wr_valid = 1'b1;
        repeat (50) @(negedge clk);
        wr_valid = 1'b0;
        chk(acks == 0 && !init_active, "R6", "unarmed write early", acks, 0);
        // early trigger, CAS latency 2
        do_init(3'd2, 1'b0);
        // R8: further armed writes after active
        @(negedge clk);
        wr_valid = 1'b1; init_req = 1'b1;
        repeat (100) @(negedge clk);
        wr_valid = 1'b0;
        chk(acks == 1, "R8", "no extra ack", acks, 1);
        chk(init_active == 1'b1, "R7", "active held", init_active, 1);
        chk(ncmd == N_REF + 2, "R8", "no extra commands", ncmd, N_REF + 2);

        reset_phase();
        while (cyc < WAIT_CYC + 500) @(negedge clk);
        // R6: unarmed writes once the delay has elapsed
        wr_valid = 1'b1;
        repeat (100) @(negedge clk);
        wr_valid = 1'b0;
        chk(ncmd == 0 && acks == 0 && !init_active, "R6", "unarmed write late", ncmd, 0);
        repeat (3) @(negedge clk);
        // late trigger, CAS latency 5
        do_init(3'd5, 1'b1);
        repeat (10) @(negedge clk);
        chk(init_active == 1'b1, "R7", "active held run 2", init_active, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL R7 watchdog expired actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule